// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to a keyboard on the two-wire PS/2 link and hands the received scan codes to a host in the same clock domain. Both link wires pass through a flop synchronizer. The receiver samples the data wire on every falling edge of the keyboard clock, builds a byte from each 11-edge frame and writes it into a small ring of pending codes. A pause longer than a set number of milliseconds between two clock edges throws away any half-built frame, so a glitch or a keyboard reset cannot leave the receiver out of step for good.

On the host side, the release prefix 0xF0 never reaches the reader as data. A read that meets the prefix drops it, raises a sticky break flag and returns the byte after it. The `avail_o` output stays low while a prefix is the only pending entry, so the host never wakes up for half of a release sequence. The host clears the break flag by taking it.

Top module: `ps2_scan_rx`

## Requirements
- R1: A frame is 11 falling edges of the keyboard clock. The data wire sampled at edges 1 to 8 (the first edge is edge 0) forms the byte, least significant bit first. The start, parity and stop bits (edges 0, 9 and 10) are not checked, so a frame with wrong values in them still delivers its byte.
- R2: Both link wires pass through SYNC_STAGES flops. Only a falling edge of the synchronized keyboard clock advances the frame. A data change while the clock is high has no effect.
- R3: If more than IDLE_MS milliseconds pass between two falling clock edges, the partial byte and the edge count are cleared before the new edge is handled. A pause well under IDLE_MS leaves the frame in progress intact.
- R4: The ring holds at most DEPTH-1 pending bytes. A byte that completes while DEPTH-1 are pending is dropped, and the pending bytes and their order are unchanged.
- R5: `avail_o` is high when at least one byte is pending and the oldest pending byte is not 0xF0. It is also high when the oldest byte is 0xF0 and at least one more byte is pending behind it.
- R6: A one-cycle `rd_i` with a non-0xF0 oldest byte consumes that byte. One cycle later the block pulses `rd_ack_o` with `rd_valid_o` high and `rd_code_o` equal to the byte. Bytes come out in arrival order.
- R7: A read whose oldest byte is 0xF0, with another byte behind it, consumes both entries, returns the second one as the code (whatever its value) and sets `brk_o`.
- R8: A read whose only pending byte is 0xF0 consumes it, sets `brk_o` and acknowledges with `rd_valid_o` low.
- R9: A read with nothing pending acknowledges with `rd_valid_o` low and changes neither the ring nor `brk_o`.
- R10: `brk_take_i` clears `brk_o` on the next cycle. If a read sets the flag in the same cycle, the flag stays set.
- R11: After reset, `avail_o`, `rd_ack_o`, `rd_valid_o`, `brk_o` and `rd_code_o` are all zero.
- R12: A byte completing in the same cycle as a read of a non-empty, non-full ring is stored, and the read still returns the oldest byte. No byte is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Keyboard clock wire, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data wire, asynchronous |
| rd_i | input | 1 | One-cycle read strobe |
| brk_take_i | input | 1 | Clears the break flag |
| avail_o | output | 1 | A code can be read |
| rd_ack_o | output | 1 | Pulses one cycle after each read strobe |
| rd_valid_o | output | 1 | The acknowledged read returned a code |
| rd_code_o | output | 8 | Returned scan code |
| brk_o | output | 1 | Sticky release flag |

## Verification
The functions most likely to collide are a frame finishing and the host reading in the same cycle, because the write pointer and the read pointer both move. The bench keeps a few bytes pending and sends a frame's final clock edge. It then issues a single read strobe at each offset from zero to seven cycles after that edge, so one of the offsets lands on the write cycle. Each read must return the expected oldest byte, and a final drain must give every byte once, in arrival order. A second collision, a break-flag take in the same cycle as a read that sets the flag, is judged by the flag still being set afterwards.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  localparam logic [7:0] BRK_PREFIX  = 8'hF0;
  localparam int         FRAME_EDGES = 11;
  localparam int         DATA_FIRST  = 1;
  localparam int         DATA_LAST   = 8;

  typedef struct packed {
    logic       vld;
    logic [7:0] code;
  } rx_byte_t;

endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = d_i;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end

    // the idle level of both wires is high, so reset to ones
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ps2_rx_framer.sv
module ps2_rx_framer
  import ps2_rx_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int IDLE_MS = 250
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     kclk_s,
  input  logic     kdat_s,
  output rx_byte_t byte_o
);

  localparam int              TICK_DIV  = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int              PW        = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0]   TICK_LAST = PW'(TICK_DIV - 1);
  localparam int              MSW       = $clog2(IDLE_MS + 2);
  localparam logic [MSW-1:0]  MS_LIM    = MSW'(IDLE_MS);
  localparam logic [MSW-1:0]  MS_SAT    = MSW'(IDLE_MS + 1);
  localparam logic [3:0]      LAST_EDGE = 4'(FRAME_EDGES - 1);

  logic           kclk_q;
  logic [3:0]     cnt_q, cnt_d, cnt_base;
  logic [7:0]     sh_q, sh_d, sh_base;
  logic [PW-1:0]  pre_q, pre_d;
  logic [MSW-1:0] ms_q, ms_d;
  rx_byte_t       out_q, out_d;
  logic           fall, tick, stale;
  logic [2:0]     bidx;

  assign fall  = kclk_q & ~kclk_s;
  assign tick  = (pre_q == TICK_LAST);
  assign stale = (ms_q > MS_LIM);
  assign bidx  = 3'(cnt_base - 4'd1);

  always_comb begin
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    pre_d    = pre_q;
    ms_d     = ms_q;
    out_d    = '{vld: 1'b0, code: out_q.code};
    cnt_base = stale ? 4'd0 : cnt_q;
    sh_base  = stale ? 8'd0 : sh_q;
    if (fall) begin
      pre_d = '0;
      ms_d  = '0;
      if (cnt_base >= 4'(DATA_FIRST) && cnt_base <= 4'(DATA_LAST)) begin
        sh_base[bidx] = kdat_s;
      end
      if (cnt_base == LAST_EDGE) begin
        out_d = '{vld: 1'b1, code: sh_base};
        cnt_d = '0;
        sh_d  = '0;
      end else begin
        cnt_d = cnt_base + 4'd1;
        sh_d  = sh_base;
      end
    end else if (tick) begin
      pre_d = '0;
      if (ms_q != MS_SAT) ms_d = ms_q + MSW'(1);
    end else begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kclk_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '0;
      pre_q  <= '0;
      ms_q   <= '0;
      out_q  <= '0;
    end else begin
      kclk_q <= kclk_s;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      pre_q  <= pre_d;
      ms_q   <= ms_d;
      out_q  <= out_d;
    end
  end

  assign byte_o = out_q;

  assert_edge_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_EDGE);

  assert_byte_after_last_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !stale && cnt_q == LAST_EDGE) |=> (byte_o.vld && cnt_q == 4'd0));

  assert_fall_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

  assert_stale_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && stale) |=> (cnt_q == 4'd1));

endmodule

// File: rtl/ps2_rx_ring.sv
module ps2_rx_ring
  import ps2_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rx_byte_t   push_i,
  input  logic       rd_i,
  input  logic       brk_take_i,
  output logic       avail_o,
  output logic       rd_ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_code_o,
  output logic       brk_o
);

  localparam int            AW       = $clog2(DEPTH);
  localparam logic [AW-1:0] FULL_CNT = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] head_q, head_d, tail_q, tail_d;
  logic [AW-1:0] cnt, p1, p2;
  logic [7:0]    first, second;
  logic          empty, full, first_brk, wr_en;
  logic          ack_q, vld_q, vld_d, brk_q, brk_d, brk_set;
  logic [7:0]    code_q, code_d;

  assign cnt       = head_q - tail_q;
  assign empty     = (cnt == '0);
  assign full      = (cnt == FULL_CNT);
  assign p1        = tail_q + AW'(1);
  assign p2        = tail_q + AW'(2);
  assign first     = mem[p1];
  assign second    = mem[p2];
  assign first_brk = (first == BRK_PREFIX);
  assign wr_en     = push_i.vld & ~full;
  assign head_d    = wr_en ? head_q + AW'(1) : head_q;

  always_comb begin
    tail_d  = tail_q;
    vld_d   = 1'b0;
    code_d  = code_q;
    brk_set = 1'b0;
    if (rd_i && !empty) begin
      if (first_brk) begin
        brk_set = 1'b1;
        if (cnt > AW'(1)) begin
          tail_d = p2;
          vld_d  = 1'b1;
          code_d = second;
        end else begin
          tail_d = p1;
        end
      end else begin
        tail_d = p1;
        vld_d  = 1'b1;
        code_d = first;
      end
    end
    brk_d = brk_set ? 1'b1 : (brk_take_i ? 1'b0 : brk_q);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[head_d] <= push_i.code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      ack_q  <= 1'b0;
      vld_q  <= 1'b0;
      code_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      ack_q  <= rd_i;
      vld_q  <= vld_d;
      code_q <= code_d;
      brk_q  <= brk_d;
    end
  end

  assign avail_o    = !empty && (!first_brk || cnt > AW'(1));
  assign rd_ack_o   = ack_q;
  assign rd_valid_o = vld_q;
  assign rd_code_o  = code_q;
  assign brk_o      = brk_q;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i.vld && full) |=> (head_q == $past(head_q)));

  assert_ack_follows_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_ack_o);

  assert_prefix_sets_brk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !empty && first_brk) |=> brk_o);

  assert_empty_read_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && empty) |=> (rd_ack_o && !rd_valid_o && tail_q == $past(tail_q)));

  assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_take_i && !rd_i) |=> !brk_o);

endmodule

// File: rtl/ps2_scan_rx.sv
module ps2_scan_rx
  import ps2_rx_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int IDLE_MS     = 250,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       rd_i,
  input  logic       brk_take_i,
  output logic       avail_o,
  output logic       rd_ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_code_o,
  output logic       brk_o
);

  logic [1:0] wires_s;
  rx_byte_t   rx_byte;

  ps2_rx_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ps2_dat_i, ps2_clk_i}),
    .q_o   (wires_s)
  );

  ps2_rx_framer #(
    .CLK_HZ  (CLK_HZ),
    .IDLE_MS (IDLE_MS)
  ) u_framer (
    .clk    (clk),
    .rst_n  (rst_n),
    .kclk_s (wires_s[0]),
    .kdat_s (wires_s[1]),
    .byte_o (rx_byte)
  );

  ps2_rx_ring #(
    .DEPTH (DEPTH)
  ) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (rx_byte),
    .rd_i       (rd_i),
    .brk_take_i (brk_take_i),
    .avail_o    (avail_o),
    .rd_ack_o   (rd_ack_o),
    .rd_valid_o (rd_valid_o),
    .rd_code_o  (rd_code_o),
    .brk_o      (brk_o)
  );

endmodule

// File: tb/ps2_scan_rx_bench.sv
module ps2_scan_rx_bench;

  localparam int CLK_HZ  = 4000;
  localparam int IDLE_MS = 250;
  localparam int DEPTH   = 16;
  localparam int HALF    = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2_clk = 1'b1;
  logic       ps2_dat = 1'b1;
  logic       rd = 1'b0;
  logic       brk_take = 1'b0;
  logic       avail, ack, vld, brk;
  logic [7:0] code;

  int n_chk = 0;
  int n_bad = 0;
  bit [7:0] q[$];
  bit       brk_m = 1'b0;

  always #4 clk = ~clk;

  ps2_scan_rx #(
    .CLK_HZ  (CLK_HZ),
    .IDLE_MS (IDLE_MS),
    .DEPTH   (DEPTH)
  ) u_ps2_scan_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ps2_clk_i  (ps2_clk),
    .ps2_dat_i  (ps2_dat),
    .rd_i       (rd),
    .brk_take_i (brk_take),
    .avail_o    (avail),
    .rd_ack_o   (ack),
    .rd_valid_o (vld),
    .rd_code_o  (code),
    .brk_o      (brk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_avail();
    if (q.size() == 0) return 1'b0;
    if (q[0] == 8'hF0) return q.size() >= 2;
    return 1'b1;
  endfunction

  function automatic void model_push(input bit [7:0] b);
    if (q.size() < DEPTH - 1) q.push_back(b);
  endfunction

  function automatic bit [10:0] frame_bits(input bit [7:0] b, input bit good);
    frame_bits = {good ? 1'b1 : 1'b0, good ? ~^b : ^b, b, good ? 1'b0 : 1'b1};
  endfunction

  task automatic send_edge(input bit v);
    @(negedge clk) ps2_dat = v;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    ps2_clk = 1'b1;
  endtask

  task automatic send_frame(input bit [7:0] b, input bit good, input int stall_at, input int stall_cyc);
    bit [10:0] f = frame_bits(b, good);
    for (int i = 0; i < 11; i++) begin
      send_edge(f[i]);
      if (i == stall_at) repeat (stall_cyc) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input string req);
    bit       ev = 1'b0;
    bit [7:0] ec = 8'h00;
    if (q.size() != 0) begin
      if (q[0] == 8'hF0) begin
        void'(q.pop_front());
        brk_m = 1'b1;
        if (q.size() != 0) begin ev = 1'b1; ec = q.pop_front(); end
      end else begin
        ev = 1'b1; ec = q.pop_front();
      end
    end
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    chk({req, " ack"}, int'(ack), 1);
    chk({req, " valid"}, int'(vld), int'(ev));
    if (ev) chk({req, " code"}, int'(code), int'(ec));
    chk({req, " brk"}, int'(brk), int'(brk_m));
  endtask

  task automatic take_brk();
    @(negedge clk) chk("R10 flag before take", int'(brk), int'(brk_m));
    brk_take = 1'b1;
    @(negedge clk) brk_take = 1'b0;
    brk_m = 1'b0;
    chk("R10 flag after take", int'(brk), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk("R11 avail", int'(avail), 0);
    chk("R11 ack", int'(ack), 0);
    chk("R11 valid", int'(vld), 0);
    chk("R11 brk", int'(brk), 0);
    chk("R11 code", int'(code), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2: plain frame and a frame with wrong framing bits
    send_frame(8'hA5, 1'b1, -1, 0); model_push(8'hA5);
    chk("R5 avail one byte", int'(avail), int'(model_avail()));
    send_frame(8'h3B, 1'b0, -1, 0); model_push(8'h3B);
    do_read("R1 R2 R6 first");
    do_read("R1 R6 bad framing bits ignored");

    // R9: empty read
    do_read("R9 empty");
    chk("R9 avail stays low", int'(avail), 0);

    // R3: pause under the limit keeps the frame
    send_frame(8'h3C, 1'b1, 4, 600); model_push(8'h3C);
    do_read("R3 short pause kept");
    // R3: partial frame then a long gap is discarded
    begin
      bit [10:0] f = frame_bits(8'hFF, 1'b1);
      for (int i = 0; i < 4; i++) send_edge(f[i]);
    end
    repeat (1200) @(negedge clk);
    send_frame(8'h5A, 1'b1, -1, 0); model_push(8'h5A);
    do_read("R3 stale partial dropped");
    chk("R3 nothing left", int'(avail), 0);

    // R5 R8: lone prefix
    send_frame(8'hF0, 1'b1, -1, 0); model_push(8'hF0);
    chk("R5 lone prefix not avail", int'(avail), 0);
    do_read("R8 lone prefix read");
    take_brk();
    // R7: prefix followed by a byte
    send_frame(8'hF0, 1'b1, -1, 0); model_push(8'hF0);
    send_frame(8'h1C, 1'b1, -1, 0); model_push(8'h1C);
    chk("R5 prefix plus byte avail", int'(avail), 1);
    do_read("R7 prefix folded");
    // R10: take in the same cycle as a read that sets the flag
    send_frame(8'hF0, 1'b1, -1, 0); model_push(8'hF0);
    send_frame(8'h29, 1'b1, -1, 0); model_push(8'h29);
    take_brk();
    @(negedge clk) begin rd = 1'b1; brk_take = 1'b1; end
    @(negedge clk) begin rd = 1'b0; brk_take = 1'b0; end
    void'(q.pop_front()); void'(q.pop_front()); brk_m = 1'b1;
    chk("R10 set wins code", int'(code), 8'h29);
    chk("R10 set wins flag", int'(brk), 1);
    take_brk();

    // R4: overflow
    for (int i = 0; i < DEPTH + 1; i++) begin
      send_frame(8'(8'h40 + i), 1'b1, -1, 0);
      model_push(8'(8'h40 + i));
    end
    chk("R4 avail when full", int'(avail), 1);
    for (int i = 0; i < DEPTH - 1; i++) do_read("R4 drain order");
    do_read("R4 R9 dropped bytes absent");

    // R12: frame completion against a read at each offset
    send_frame(8'h61, 1'b1, -1, 0); model_push(8'h61);
    send_frame(8'h62, 1'b1, -1, 0); model_push(8'h62);
    for (int o = 0; o < 8; o++) begin
      bit [7:0]  nb = 8'(8'h70 + o);
      bit [10:0] f  = frame_bits(nb, 1'b1);
      bit [7:0]  ec;
      for (int i = 0; i < 10; i++) send_edge(f[i]);
      @(negedge clk) ps2_dat = f[10];
      repeat (HALF) @(negedge clk);
      ps2_clk = 1'b0;
      repeat (o) @(negedge clk);
      ec = q.pop_front();
      rd = 1'b1;
      @(negedge clk) rd = 1'b0;
      chk("R12 collide valid", int'(vld), 1);
      chk("R12 collide code", int'(code), int'(ec));
      repeat (HALF) @(negedge clk);
      ps2_clk = 1'b1;
      model_push(nb);
      repeat (4) @(negedge clk);
    end
    while (q.size() != 0) do_read("R12 drain order");
    chk("R12 empty after drain", int'(avail), 0);

    // random mix
    for (int n = 0; n < 30; n++) begin
      bit [7:0] b = ($urandom % 4 == 0) ? 8'hF0 : 8'($urandom % 256);
      int act = $urandom % 3;
      send_frame(b, 1'b1, -1, 0); model_push(b);
      chk("R5 random avail", int'(avail), int'(model_avail()));
      if (act == 0) do_read("R6 R7 random read");
      else if (act == 1) take_brk();
    end
    while (q.size() != 0) do_read("R6 R7 R8 random drain");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule